// File: doc/BRIEF.md
# Reorder Buffer with Mispredict-Gated Retirement

This block is the in-order retirement buffer of an out-of-order core. The front end allocates instructions at the tail in program order and receives a tag for each one. Execution units later mark entries complete by slot index. Each cycle the buffer retires up to `RET_W` consecutive completed entries from the head, and the oldest of them appears on retire slot 0.

A branch unit may report a completion with a mispredict flag. The flush that follows reaches the buffer at least one cycle later and possibly much later. A two-state controller keeps retirement from ever passing such a branch before its flush arrives. The states are `ST_RUN` (normal retirement) and `ST_WAIT_FLUSH` (retirement gated at the branch). The transition `go_wait` (RUN to WAIT_FLUSH) fires when a mispredicted completion is accepted. The transition `flush_seen` (WAIT_FLUSH to RUN) fires when a flush request is present. While the controller waits, entries older than the branch still drain. The flush discards every entry younger than the branch and rewinds the tail to the slot just after it. Only then may the branch retire, and it retires as the last entry of its group. A late flush therefore never meets an instruction that has already left the machine.

Tags are circular indices with one extra wrap bit, so age comparisons and the tail rewind stay correct when the index wraps. Only one mispredicted branch may be outstanding at a time.

Top module: `rob_flush_gate`

## Requirements
- R1: After reset the buffer is empty, `ret_valid` is all zero, `alloc_ready` is high and `alloc_tag` is 0.
- R2: An allocation is taken only when `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low when DEPTH entries are held or when `flush_valid` is high. `alloc_tag` is the tail tag: bits [IDX_W-1:0] give the slot and bit IDX_W is the wrap bit, which toggles each time the slot index passes DEPTH-1. The tag increments by one per accepted allocation.
- R3: Retirement is in allocation order. Up to RET_W consecutive completed entries leave the head per cycle, slot 0 being the oldest. Retirement stops at the first entry that is not complete, whatever order the completions came in.
- R4: A completion with `cmp_mispred` high marks the entry as a mispredicted branch. From the next cycle the controller is in ST_WAIT_FLUSH.
- R5: In ST_WAIT_FLUSH neither the mispredicted branch nor any entry younger than it appears on the retire output. Older completed entries still retire.
- R6: Retirement stays gated for as many cycles as the flush takes to arrive.
- R7: A flush carrying the branch's full tag keeps the branch and every older entry, discards every younger entry, sets the tail to the branch tag plus one and returns the controller to ST_RUN in the next cycle.
- R8: After its flush, the mispredicted branch retires as the highest-numbered valid slot of its cycle. No younger entry retires in the same cycle as the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_data | input | PAY_W | Payload stored with the new entry |
| alloc_ready | output | 1 | Allocation can be taken this cycle |
| alloc_tag | output | IDX_W+1 | Tag of the entry being allocated (slot plus wrap bit) |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | IDX_W | Slot index of the completing entry |
| cmp_mispred | input | 1 | Completing entry is a mispredicted branch |
| flush_valid | input | 1 | Delayed flush request for the outstanding branch |
| flush_tag | input | IDX_W+1 | Full tag of the mispredicted branch |
| ret_valid | output | RET_W | Per-slot retire strobe, slot 0 oldest |
| ret_data | output | RET_W*PAY_W | Payloads of the retiring entries, slot k at bits [k*PAY_W +: PAY_W] |

## Verification
Two functions can occur in the same cycle. One is the arrival of the flush. The other is retirement at the head, where older entries drain while the entries younger than the branch are being discarded. A directed sequence completes the younger entries ahead of the branch, reports the branch as mispredicted, holds the flush back for several cycles and then sends it. In each of these cycles the bench samples the retire slots and `alloc_ready`. In the cycle after the flush it expects the branch alone on slot 0 and the tail at the branch tag plus one. Random traffic then repeats the pattern with flush delays of one to six cycles. Allocations and completions run alongside. A scoreboard marks every retired entry younger than an open branch as a failure.

// File: rtl/rob_gate_pkg.sv
package rob_gate_pkg;

    typedef enum logic {
        ST_RUN        = 1'b0,
        ST_WAIT_FLUSH = 1'b1
    } gate_state_e;

endpackage

// File: rtl/rob_hold_fsm.sv
module rob_hold_fsm
    import rob_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mis_evt,
    input  logic flush_evt,
    output logic holding
);

    gate_state_e state_q;
    gate_state_e state_d;

    // next-state: go_wait and flush_seen transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:        if (mis_evt)   state_d = ST_WAIT_FLUSH;
            ST_WAIT_FLUSH: if (flush_evt) state_d = ST_RUN;
            default:                      state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        holding = (state_q == ST_WAIT_FLUSH);
    end

    a_r4_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_evt && !holding) |=> holding);

    a_r7_flush_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_evt && holding) |=> !holding);

    a_r6_wait_until_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !flush_evt) |=> holding);

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
    parameter int DEPTH = 8,
    parameter int PAY_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [PAY_W-1:0]            wr_data,
    input  logic                        cmp_en,
    input  logic [IDX_W-1:0]            cmp_idx,
    input  logic                        cmp_mis,
    output logic [DEPTH-1:0]            done_vec,
    output logic [DEPTH-1:0]            mis_vec,
    output logic [DEPTH-1:0][PAY_W-1:0] data_arr
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_vec[i] <= 1'b0;
                mis_vec[i]  <= 1'b0;
                data_arr[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                done_vec[i] <= 1'b0;
                mis_vec[i]  <= 1'b0;
                data_arr[i] <= wr_data;
            end else if (cmp_en && (cmp_idx == IDX_W'(i))) begin
                done_vec[i] <= 1'b1;
                mis_vec[i]  <= cmp_mis;
            end
        end
    end

    a_r4_mark_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !(wr_en && wr_idx == cmp_idx)) |=>
            (done_vec[$past(cmp_idx)] && (mis_vec[$past(cmp_idx)] == $past(cmp_mis))));

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
    parameter int DEPTH = 8,
    parameter int RET_W = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1,
    localparam int CNT_W = $clog2(RET_W + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            head_idx,
    input  logic [PTR_W-1:0]            count,
    input  logic [DEPTH-1:0]            done_vec,
    input  logic [DEPTH-1:0]            mis_vec,
    input  logic                        holding,
    output logic [RET_W-1:0]            ret_vld,
    output logic [RET_W-1:0][IDX_W-1:0] ret_idx,
    output logic [CNT_W-1:0]            ret_num
);

    logic go_c;

    always_comb begin
        go_c    = 1'b1;
        ret_num = '0;
        for (int k = 0; k < RET_W; k++) begin
            ret_idx[k] = head_idx + IDX_W'(k);
            ret_vld[k] = go_c && (PTR_W'(k) < count) && done_vec[ret_idx[k]]
                         && !(mis_vec[ret_idx[k]] && holding);
            if (!ret_vld[k] || mis_vec[ret_idx[k]]) go_c = 1'b0;
            if (ret_vld[k]) ret_num = ret_num + CNT_W'(1);
        end
    end

    for (genvar k = 0; k < RET_W; k++) begin : g_chk
        a_r5_wait_blocks_branch: assert property (@(posedge clk) disable iff (!rst_n)
            (holding && ret_vld[k]) |-> !mis_vec[ret_idx[k]]);
        if (k < RET_W - 1) begin : g_pair
            a_r8_branch_is_last: assert property (@(posedge clk) disable iff (!rst_n)
                (ret_vld[k] && mis_vec[ret_idx[k]]) |-> !ret_vld[k+1]);
            a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
                ret_vld[k+1] |-> ret_vld[k]);
        end
    end

endmodule

// File: rtl/rob_flush_gate.sv
module rob_flush_gate #(
    parameter int DEPTH = 8,
    parameter int RET_W = 2,
    parameter int PAY_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1,
    localparam int CNT_W = $clog2(RET_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_valid,
    input  logic [PAY_W-1:0]       alloc_data,
    output logic                   alloc_ready,
    output logic [PTR_W-1:0]       alloc_tag,
    input  logic                   cmp_valid,
    input  logic [IDX_W-1:0]       cmp_tag,
    input  logic                   cmp_mispred,
    input  logic                   flush_valid,
    input  logic [PTR_W-1:0]       flush_tag,
    output logic [RET_W-1:0]       ret_valid,
    output logic [RET_W*PAY_W-1:0] ret_data
);

    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] ONE_P    = PTR_W'(1);

    logic [PTR_W-1:0]            head_q, tail_q, count;
    logic                        alloc_fire, holding;
    logic [DEPTH-1:0]            done_vec, mis_vec;
    logic [DEPTH-1:0][PAY_W-1:0] data_arr;
    logic [RET_W-1:0][IDX_W-1:0] ret_idx;
    logic [CNT_W-1:0]            ret_num;

    assign count       = tail_q - head_q;
    assign alloc_ready = (count != FULL_CNT) && !flush_valid;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(ret_num);
            if (flush_valid)     tail_q <= flush_tag + ONE_P;
            else if (alloc_fire) tail_q <= tail_q + ONE_P;
        end
    end

    rob_hold_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mis_evt   (cmp_valid && cmp_mispred),
        .flush_evt (flush_valid),
        .holding   (holding)
    );

    rob_entry_store #(.DEPTH(DEPTH), .PAY_W(PAY_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (alloc_fire),
        .wr_idx   (tail_q[IDX_W-1:0]),
        .wr_data  (alloc_data),
        .cmp_en   (cmp_valid),
        .cmp_idx  (cmp_tag),
        .cmp_mis  (cmp_mispred),
        .done_vec (done_vec),
        .mis_vec  (mis_vec),
        .data_arr (data_arr)
    );

    rob_retire_sel #(.DEPTH(DEPTH), .RET_W(RET_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .head_idx (head_q[IDX_W-1:0]),
        .count    (count),
        .done_vec (done_vec),
        .mis_vec  (mis_vec),
        .holding  (holding),
        .ret_vld  (ret_valid),
        .ret_idx  (ret_idx),
        .ret_num  (ret_num)
    );

    for (genvar k = 0; k < RET_W; k++) begin : g_out
        assign ret_data[k*PAY_W +: PAY_W] = data_arr[ret_idx[k]];
    end

    a_r2_never_overfull: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    a_r7_tail_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (tail_q == $past(flush_tag) + ONE_P));

    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (count == '0));

endmodule

// File: tb/rob_flush_gate_tb.sv
`timescale 1ns/1ps
module rob_flush_gate_tb;

    localparam int DEPTH = 8;
    localparam int RET_W = 2;
    localparam int PW    = 16;
    localparam int IW    = $clog2(DEPTH);
    localparam int TW    = IW + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [PW-1:0]     alloc_data = '0;
    logic              alloc_ready;
    logic [TW-1:0]     alloc_tag;
    logic              cmp_valid = 1'b0;
    logic [IW-1:0]     cmp_tag = '0;
    logic              cmp_mispred = 1'b0;
    logic              flush_valid = 1'b0;
    logic [TW-1:0]     flush_tag = '0;
    logic [RET_W-1:0]  ret_valid;
    logic [RET_W*PW-1:0] ret_data;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    int next_id = 0;
    int tag_of[4096];
    bit sent[4096];
    int hold_id = -1;
    int last_br = -1;
    int multi_seen = 0;

    always #10 clk = ~clk;

    rob_flush_gate #(.DEPTH(DEPTH), .RET_W(RET_W), .PAY_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_data(alloc_data),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_mispred(cmp_mispred),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .ret_valid(ret_valid), .ret_data(ret_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, bookkeeping at the negedge
    task automatic step(input bit a, input bit c, input int cid, input bit m, input bit f);
        @(posedge clk); #1;
        alloc_valid = a;
        alloc_data  = PW'(next_id);
        cmp_valid   = c;
        cmp_tag     = c ? IW'(tag_of[cid]) : '0;
        cmp_mispred = m;
        flush_valid = f;
        flush_tag   = f ? TW'(tag_of[hold_id]) : '0;
        @(negedge clk);
        if (a && alloc_ready) begin
            tag_of[next_id] = int'(alloc_tag);
            exp_q.push_back(next_id);
            next_id++;
        end
        if (c) begin
            sent[cid] = 1'b1;
            if (m) hold_id = cid;
        end
        if (f) begin
            while (exp_q.size() > 0 && exp_q[$] > hold_id) void'(exp_q.pop_back());
            last_br = hold_id;
            hold_id = -1;
        end
    endtask

    // monitor: scoreboard compare of every retired entry
    always @(negedge clk) begin
        if (rst_n) begin
            if (&ret_valid) multi_seen++;
            for (int k = 0; k < RET_W; k++) begin
                if (ret_valid[k]) begin
                    int id;
                    id = int'(ret_data[k*PW +: PW]);
                    if (exp_q.size() == 0) chk(1'b0, "R3 retire with empty scoreboard", id, -1);
                    else begin
                        chk(exp_q[0] == id, "R3 retire order", id, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                    if (hold_id >= 0)
                        chk(id < hold_id, "R5 retired at/after open branch", id, hold_id - 1);
                    if (id == last_br && k < RET_W - 1)
                        chk(!ret_valid[k+1], "R8 younger retired with branch", int'(ret_valid[k+1]), 0);
                end
            end
        end
    end

    initial begin
        #(20.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    function automatic int pick_unsent();
        int cand[$];
        foreach (exp_q[i]) if (!sent[exp_q[i]]) cand.push_back(exp_q[i]);
        if (cand.size() == 0) return -1;
        return cand[$urandom_range(cand.size() - 1)];
    endfunction

    initial begin
        int a0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        step(0, 0, 0, 0, 0);
        chk(ret_valid == '0, "R1 ret_valid after reset", int'(ret_valid), 0);
        chk(alloc_ready == 1'b1, "R1 alloc_ready after reset", int'(alloc_ready), 1);
        chk(alloc_tag == '0, "R1 alloc_tag after reset", int'(alloc_tag), 0);

        // R2 fill to DEPTH, tags count up
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 0, 0, 0, 0);
            chk(tag_of[i] == i, "R2 alloc tag sequence", tag_of[i], i);
        end
        step(1, 0, 0, 0, 0);
        chk(alloc_ready == 1'b0, "R2 refused when full", int'(alloc_ready), 0);
        chk(exp_q.size() == DEPTH, "R2 no allocation when full", exp_q.size(), DEPTH);
        chk(int'(alloc_tag) == DEPTH, "R2 wrap bit set after DEPTH allocs", int'(alloc_tag), DEPTH);

        // R3 complete out of order, youngest first
        for (int i = DEPTH - 1; i >= 0; i--) step(0, 1, i, 0, 0);
        repeat (6) step(0, 0, 0, 0, 0);
        chk(exp_q.size() == 0, "R3 drained after completions", exp_q.size(), 0);
        chk(multi_seen > 0, "R3 full-width retire seen", multi_seen, 1);

        // R4..R8 directed mispredict with younger entries already complete
        a0 = next_id;
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
        for (int i = 1; i < 4; i++) step(0, 1, a0 + i, 0, 0);
        step(0, 1, a0, 1, 0);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 0, 0, 0);
            chk(ret_valid == '0, "R6 gated while waiting for flush", int'(ret_valid), 0);
        end
        step(1, 0, 0, 0, 1);
        chk(ret_valid == '0, "R5 nothing retires in flush cycle", int'(ret_valid), 0);
        chk(alloc_ready == 1'b0, "R2 refused during flush", int'(alloc_ready), 0);
        step(0, 0, 0, 0, 0);
        chk(ret_valid == 2'b01, "R8 branch retires alone", int'(ret_valid), 1);
        chk(int'(ret_data[PW-1:0]) == a0, "R8 branch payload", int'(ret_data[PW-1:0]), a0);
        chk(int'(alloc_tag) == ((tag_of[a0] + 1) % (2 * DEPTH)), "R7 tail rewound to branch+1",
            int'(alloc_tag), (tag_of[a0] + 1) % (2 * DEPTH));
        step(0, 0, 0, 0, 0);
        chk(exp_q.size() == 0, "R7 younger entries discarded", exp_q.size(), 0);

        // random traffic with delayed flushes
        begin
            int age = 0;
            int dly = 1;
            for (int cyc = 0; cyc < 3000; cyc++) begin
                bit a, c, m, f;
                int cid;
                a   = ($urandom_range(3) != 0) && (next_id < 4000);
                cid = pick_unsent();
                c   = (cid >= 0) && ($urandom_range(3) != 0);
                m   = c && (hold_id < 0) && ($urandom_range(5) == 0);
                f   = (hold_id >= 0) && (age >= dly);
                if (hold_id >= 0) age++;
                step(a, c, c ? cid : 0, m, f);
                if (m) begin
                    age = 0;
                    dly = 1 + $urandom_range(5);
                end
            end
            for (int cyc = 0; cyc < 400 && (exp_q.size() > 0 || hold_id >= 0); cyc++) begin
                int cid;
                bit f;
                cid = pick_unsent();
                f   = (hold_id >= 0);
                step(0, (cid >= 0) && !f, (cid >= 0) ? cid : 0, 0, f);
            end
            repeat (4) step(0, 0, 0, 0, 0);
            chk(exp_q.size() == 0, "R7 random run fully drained", exp_q.size(), 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule